// File: doc/BRIEF.md
# Branch Condition and Target Evaluator

This purely combinational unit resolves one conditional branch in a single pass. It takes the branch kind, a four-bit condition code, two 32-bit operand values, a four-bit constant selector, a raw offset field, the current program counter and the instruction length. It produces a taken flag and the address of the next instruction.

Five families of test are supported:
- register against register: equality, signed order, unsigned order, mask tests and bit tests;
- register against zero;
- register against a signed constant drawn from a fixed 16-entry table;
- register against an unsigned constant drawn from a second table;
- a compact two-byte form that only tests for zero.

The decoder in front of the unit supplies the kind and the fields. The fetch stage uses `next_pc` directly.

The taken address is the current PC plus four plus the extended offset. The offset is extended in one of three ways, depending on the kind. A branch that is not taken falls through by the instruction length. All address arithmetic wraps at 32 bits.

Top module: `branch_resolve`

## Requirements
- R1: `br_kind` encodes the family: 0 register-register, 1 zero compare, 2 signed constant, 3 unsigned constant, 4 compact zero test. Kinds 5 to 7 are reserved and never taken.
- R2: For kind 0, `br_cond[2:0]` selects the test and `br_cond[3]` inverts it. Code 1 tests a==b, code 2 tests signed a<b and code 3 tests unsigned a<b, so that 9, 10 and 11 give not-equal, signed greater-or-equal and unsigned greater-or-equal.
- R3: For kind 0, code 0 is taken when (a AND b) is zero, and code 8 when it is nonzero. Code 4 is taken when (a AND b) equals b, and code 12 when it differs from b.
- R4: For kind 0, code 5 is taken when bit b[4:0] of a is clear, and code 13 when it is set. Codes 6 and 7 test bit {br_cond[0], const_sel} of a for clear, and codes 14 and 15 test it for set.
- R5: For kind 1, `br_cond[0]`=0 tests a==0 and `br_cond[0]`=1 tests signed a<0. `br_cond[3]` inverts the test.
- R6: For kind 2, a is compared with an entry of the signed table, indexed by `const_sel`. The entries for selectors 0 to 15 are -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128 and 256. `br_cond[0]` picks equality (0) or signed less-than (1), and `br_cond[3]` inverts.
- R7: For kind 3, the test is unsigned a < constant, and `br_cond[3]` inverts it to greater-or-equal. The constant is taken from the same table, except that selector 0 gives 32768 and selector 1 gives 65536.
- R8: For kind 4, the test is a==0, and `br_cond[3]` inverts it. The taken offset is `br_offset[5:0]`, zero-extended.
- R9: A taken branch goes to cur_pc + 4 + offset. Kinds 0, 2 and 3 sign-extend `br_offset[7:0]` and ignore the upper bits of the field. Kind 1 sign-extends all twelve bits.
- R10: A branch that is not taken goes to cur_pc + insn_len.
- R11: All next-PC arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_kind | input | 3 | Branch family |
| br_cond | input | 4 | Condition code; bit 3 inverts the test |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand, or mask, or bit index |
| const_sel | input | 4 | Constant table selector, or the low bits of the immediate bit index |
| br_offset | input | 12 | Raw offset field |
| cur_pc | input | 32 | Address of the branch |
| insn_len | input | 2 | Instruction length in bytes (2 or 3) |
| take | output | 1 | Branch taken |
| next_pc | output | 32 | Address of the next instruction |

## Verification
The bench builds the unit with its default parameters:
- a 32-bit datapath;
- offset fields of 12, 8 and 6 bits;
- the compact form enabled.

These defaults make every bit index from 0 to 31 reachable, including index 17. That index comes from the immediate bit test with the high index bit drawn from the condition code.

Both ends of the 12-bit offset range are exercised, as is the largest compact offset. Program counters close to the top of the address space show wrap-around on both the taken and the fall-through paths.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
   typedef enum logic [2:0] {
      BK_REG    = 3'd0,
      BK_ZERO   = 3'd1,
      BK_IMMS   = 3'd2,
      BK_IMMU   = 3'd3,
      BK_NARROW = 3'd4
   } brt_kind_e;
endpackage

// File: rtl/brt_const_table.sv
`timescale 1ns/1ps
module brt_const_table #(
   parameter int XLEN  = 32,
   parameter int SEL_W = 4
) (
   input  logic             use_unsigned,
   input  logic [SEL_W-1:0] sel,
   output logic [XLEN-1:0]  value
);
   localparam int ENTRIES = 2 ** SEL_W;

   function automatic logic [XLEN-1:0] entry(input int idx, input bit uns);
      if (uns && idx == 0)      return XLEN'(32768);
      else if (uns && idx == 1) return XLEN'(65536);
      else if (idx == 0)        return '1;
      else if (idx <= 8)        return XLEN'(idx);
      else if (idx == 9)        return XLEN'(10);
      else if (idx == 10)       return XLEN'(12);
      else                      return XLEN'(1) << (idx - 7);
   endfunction

   logic [XLEN-1:0] tbl_s [ENTRIES];
   logic [XLEN-1:0] tbl_u [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign tbl_s[i] = entry(i, 1'b0);
      assign tbl_u[i] = entry(i, 1'b1);
   end

   assign value = use_unsigned ? tbl_u[sel] : tbl_s[sel];
endmodule

// File: rtl/brt_cond_eval.sv
`timescale 1ns/1ps
module brt_cond_eval
   import brt_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int SEL_W     = 4,
   parameter bit NARROW_EN = 1'b1
) (
   input  brt_kind_e        kind,
   input  logic [3:0]       cond,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   input  logic [SEL_W-1:0] csel,
   input  logic [XLEN-1:0]  cval,
   output logic             take
);
   localparam int IW = $clog2(XLEN);

   if (SEL_W + 1 != IW) begin : g_bad_idx
      $error("brt_cond_eval: SEL_W + 1 must equal log2(XLEN)");
   end

   logic base;
   logic valid;

   always_comb begin
      base  = 1'b0;
      valid = 1'b1;
      case (kind)
         BK_REG: begin
            case (cond[2:0])
               3'd0:    base = ~|(a & b);
               3'd1:    base = (a == b);
               3'd2:    base = ($signed(a) < $signed(b));
               3'd3:    base = (a < b);
               3'd4:    base = ((a & b) == b);
               3'd5:    base = ~a[b[IW-1:0]];
               default: base = ~a[{cond[0], csel}];
            endcase
         end
         BK_ZERO:   base = cond[0] ? a[XLEN-1] : (a == '0);
         BK_IMMS:   base = cond[0] ? ($signed(a) < $signed(cval)) : (a == cval);
         BK_IMMU:   base = (a < cval);
         BK_NARROW: begin
            base  = (a == '0);
            valid = NARROW_EN;
         end
         default:   valid = 1'b0;
      endcase
   end

   assign take = valid & (base ^ cond[3]);

   always_comb begin
      if (!$isunknown({kind, cond, a, b})) begin
         // R2
         rr_equal_chk: assert (!(kind == BK_REG && cond[2:0] == 3'd1 && a == b)
                               || take == ~cond[3])
            else $error("equal operands gave the wrong decision");
      end
   end
endmodule

// File: rtl/brt_target_gen.sv
`timescale 1ns/1ps
module brt_target_gen
   import brt_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int OFS_W     = 12,
   parameter int SOFS_W    = 8,
   parameter int NOFS_W    = 6,
   parameter int LEN_W     = 2,
   parameter int BIAS      = 4,
   parameter bit NARROW_EN = 1'b1
) (
   input  brt_kind_e        kind,
   input  logic [OFS_W-1:0] ofs,
   input  logic [XLEN-1:0]  pc,
   input  logic [LEN_W-1:0] len,
   input  logic             take,
   output logic [XLEN-1:0]  next_pc
);
   logic [XLEN-1:0] ext_long;
   logic [XLEN-1:0] ext_short;
   logic [XLEN-1:0] ext_narrow;
   logic [XLEN-1:0] ext_sel;

   assign ext_long  = {{(XLEN-OFS_W){ofs[OFS_W-1]}}, ofs};
   assign ext_short = {{(XLEN-SOFS_W){ofs[SOFS_W-1]}}, ofs[SOFS_W-1:0]};

   if (NARROW_EN) begin : g_narrow
      assign ext_narrow = XLEN'(ofs[NOFS_W-1:0]);
   end else begin : g_no_narrow
      assign ext_narrow = '0;
   end

   always_comb begin
      case (kind)
         BK_ZERO:   ext_sel = ext_long;
         BK_NARROW: ext_sel = ext_narrow;
         default:   ext_sel = ext_short;
      endcase
   end

   assign next_pc = take ? (pc + XLEN'(BIAS) + ext_sel) : (pc + XLEN'(len));
endmodule

// File: rtl/branch_resolve.sv
`timescale 1ns/1ps
module branch_resolve
   import brt_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int SEL_W     = 4,
   parameter int OFS_W     = 12,
   parameter int SOFS_W    = 8,
   parameter int NOFS_W    = 6,
   parameter int LEN_W     = 2,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic [2:0]       br_kind,
   input  logic [3:0]       br_cond,
   input  logic [XLEN-1:0]  src_a,
   input  logic [XLEN-1:0]  src_b,
   input  logic [SEL_W-1:0] const_sel,
   input  logic [OFS_W-1:0] br_offset,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [LEN_W-1:0] insn_len,
   output logic             take,
   output logic [XLEN-1:0]  next_pc
);
   localparam int BIAS    = 4;
   localparam int MAX_FWD = BIAS + 2 ** NOFS_W - 1;

   if (!(NOFS_W < SOFS_W && SOFS_W <= OFS_W && OFS_W < XLEN)) begin : g_bad_ofs
      $error("branch_resolve: offset widths out of order");
   end
   if (XLEN < 17) begin : g_bad_xlen
      $error("branch_resolve: constant table needs at least 17 bits");
   end

   brt_kind_e       kind;
   logic [XLEN-1:0] cval;
   logic [XLEN-1:0] pc_delta;

   assign kind = brt_kind_e'(br_kind);

   brt_const_table #(.XLEN(XLEN), .SEL_W(SEL_W)) u_tbl (
      .use_unsigned (kind == BK_IMMU),
      .sel          (const_sel),
      .value        (cval)
   );

   brt_cond_eval #(.XLEN(XLEN), .SEL_W(SEL_W), .NARROW_EN(NARROW_EN)) u_cond (
      .kind (kind),
      .cond (br_cond),
      .a    (src_a),
      .b    (src_b),
      .csel (const_sel),
      .cval (cval),
      .take (take)
   );

   brt_target_gen #(
      .XLEN(XLEN), .OFS_W(OFS_W), .SOFS_W(SOFS_W), .NOFS_W(NOFS_W),
      .LEN_W(LEN_W), .BIAS(BIAS), .NARROW_EN(NARROW_EN)
   ) u_tgt (
      .kind    (kind),
      .ofs     (br_offset),
      .pc      (cur_pc),
      .len     (insn_len),
      .take    (take),
      .next_pc (next_pc)
   );

   assign pc_delta = next_pc - cur_pc;

   always_comb begin
      if (!$isunknown({br_kind, br_cond, src_a, src_b, const_sel, br_offset, cur_pc, insn_len})) begin
         // R10
         fallthru_chk: assert (take || pc_delta == XLEN'(insn_len))
            else $error("fall-through address wrong");
         // R1
         reserved_chk: assert (br_kind < 3'd5 || !take)
            else $error("reserved kind taken");
         // R8
         narrow_fwd_chk: assert (!(take && kind == BK_NARROW)
                                 || (pc_delta >= XLEN'(BIAS) && pc_delta <= XLEN'(MAX_FWD)))
            else $error("compact branch went backward or too far");
         // R9
         target_bias_chk: assert (!(take && kind == BK_REG && br_offset[SOFS_W-1:0] == '0)
                                  || pc_delta == XLEN'(BIAS))
            else $error("zero offset did not land at pc + 4");
      end
   end
endmodule

// File: tb/branch_resolve_bench.sv
`timescale 1ns/1ps
module branch_resolve_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  br_kind = '0;
   logic [3:0]  br_cond = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [3:0]  const_sel = '0;
   logic [11:0] br_offset = '0;
   logic [31:0] cur_pc = '0;
   logic [1:0]  insn_len = 2'd3;
   logic        take;
   logic [31:0] next_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic        exp_take;
      logic [31:0] exp_pc;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   branch_resolve u_branch_resolve (
      .br_kind(br_kind), .br_cond(br_cond), .src_a(src_a), .src_b(src_b),
      .const_sel(const_sel), .br_offset(br_offset), .cur_pc(cur_pc),
      .insn_len(insn_len), .take(take), .next_pc(next_pc)
   );

   function automatic logic [32:0] ref_out(
      input logic [2:0] k, input logic [3:0] c, input logic [31:0] a,
      input logic [31:0] b, input logic [3:0] cs, input logic [11:0] off,
      input logic [31:0] pc, input logic [1:0] len);
      logic [31:0] tab [16] = '{32'hFFFF_FFFF, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};
      logic [31:0] k_val, disp;
      logic hit;
      hit  = 1'b0;
      disp = {{24{off[7]}}, off[7:0]};
      k_val = tab[cs];
      if (k == 3 && cs == 0) k_val = 32768;
      if (k == 3 && cs == 1) k_val = 65536;
      if (k == 0) begin
         if (c[2:0] == 0)      hit = ((a & b) == 0);
         else if (c[2:0] == 1) hit = (a == b);
         else if (c[2:0] == 2) hit = ($signed(a) < $signed(b));
         else if (c[2:0] == 3) hit = (a < b);
         else if (c[2:0] == 4) hit = ((a & b) == b);
         else if (c[2:0] == 5) hit = (((a >> b[4:0]) & 1) == 0);
         else                  hit = (((a >> {c[0], cs}) & 1) == 0);
         hit = hit ^ c[3];
      end else if (k == 1) begin
         hit  = (c[0] ? $signed(a) < 0 : a == 0) ^ c[3];
         disp = {{20{off[11]}}, off};
      end else if (k == 2) begin
         hit = (c[0] ? $signed(a) < $signed(k_val) : a == k_val) ^ c[3];
      end else if (k == 3) begin
         hit = (a < k_val) ^ c[3];
      end else if (k == 4) begin
         hit  = (a == 0) ^ c[3];
         disp = {26'd0, off[5:0]};
      end
      return {hit, hit ? pc + 32'd4 + disp : pc + {30'd0, len}};
   endfunction

   task automatic drive(input logic [2:0] k, input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] b, input logic [3:0] cs, input logic [11:0] off,
                        input logic [31:0] pc, input logic [1:0] len,
                        input logic et, input logic [31:0] ep, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      br_kind = k; br_cond = c; src_a = a; src_b = b; const_sel = cs;
      br_offset = off; cur_pc = pc; insn_len = len;
      it.exp_take = et; it.exp_pc = ep; it.tag = tag;
      sb.push_back(it);
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (take !== it.exp_take || next_pc !== it.exp_pc) begin
            errors++;
            $display("FAIL %s: take=%0b next_pc=%08h expected take=%0b next_pc=%08h",
                     it.tag, take, next_pc, it.exp_take, it.exp_pc);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R3 idle inputs: none-test on zeros is taken to pc+4
      drive(0, 0, 0, 0, 0, 0, 0, 3, 1, 32'h4, "R3 idle");
      // R2 register compares, R9 offset
      drive(0, 1, 32'h1234, 32'h1234, 0, 12'h010, 32'h1000, 3, 1, 32'h1014, "R2 eq");
      drive(0, 9, 32'h1234, 32'h1234, 0, 12'h010, 32'h1000, 3, 0, 32'h1003, "R2 ne");
      drive(0, 2, 32'hFFFF_FFFF, 1, 0, 12'hAF0, 32'h1000, 3, 1, 32'h0FF4, "R9 R2 lt neg offset");
      drive(0, 11, 32'hFFFF_FFFF, 1, 0, 12'h004, 32'h1000, 3, 1, 32'h1008, "R2 geu");
      drive(0, 3, 32'hFFFF_FFFF, 1, 0, 12'h004, 32'h1000, 3, 0, 32'h1003, "R2 ltu");
      // R3 mask tests
      drive(0, 8, 32'hF0, 32'h10, 0, 0, 32'h1000, 3, 1, 32'h1004, "R3 any");
      drive(0, 4, 32'hFF, 32'h0F, 0, 0, 32'h1000, 3, 1, 32'h1004, "R3 all");
      drive(0, 4, 32'hF0, 32'h0F, 0, 0, 32'h1000, 3, 0, 32'h1003, "R3 all miss");
      drive(0, 12, 32'hF0, 32'h0F, 0, 0, 32'h1000, 3, 1, 32'h1004, "R3 not-all");
      // R4 bit tests
      drive(0, 5, 32'h20, 32'h25, 0, 0, 32'h1000, 3, 0, 32'h1003, "R4 reg clear");
      drive(0, 13, 32'h20, 32'h25, 0, 0, 32'h1000, 3, 1, 32'h1004, "R4 reg set");
      drive(0, 7, 32'h2_0000, 0, 1, 0, 32'h1000, 3, 0, 32'h1003, "R4 imm clear bit17");
      drive(0, 15, 32'h2_0000, 0, 1, 0, 32'h1000, 3, 1, 32'h1004, "R4 imm set bit17");
      drive(0, 6, 32'h2_0000, 0, 1, 0, 32'h1000, 3, 1, 32'h1004, "R4 imm clear bit1");
      // R5 zero compares
      drive(1, 0, 0, 0, 0, 12'h800, 32'h1000, 3, 1, 32'h0804, "R5 eqz far back");
      drive(1, 1, 32'h8000_0000, 0, 0, 12'h7FF, 32'h1000, 3, 1, 32'h1803, "R5 ltz far fwd");
      drive(1, 9, 32'h8000_0000, 0, 0, 12'h7FF, 32'h1000, 3, 0, 32'h1003, "R5 gez");
      drive(1, 8, 0, 0, 0, 0, 32'h1000, 3, 0, 32'h1003, "R5 nez");
      // R6 signed table
      drive(2, 0, 32'hFFFF_FFFF, 0, 0, 0, 32'h1000, 3, 1, 32'h1004, "R6 sel0=-1");
      drive(2, 0, 10, 0, 9, 0, 32'h1000, 3, 1, 32'h1004, "R6 sel9=10");
      drive(2, 0, 256, 0, 15, 0, 32'h1000, 3, 1, 32'h1004, "R6 sel15=256");
      drive(2, 1, 255, 0, 15, 0, 32'h1000, 3, 1, 32'h1004, "R6 lt 256");
      drive(2, 9, 31, 0, 12, 0, 32'h1000, 3, 0, 32'h1003, "R6 ge 32");
      // R7 unsigned table
      drive(3, 0, 65535, 0, 1, 0, 32'h1000, 3, 1, 32'h1004, "R7 ltu 65536");
      drive(3, 0, 32768, 0, 0, 0, 32'h1000, 3, 0, 32'h1003, "R7 ltu 32768");
      drive(3, 8, 32768, 0, 0, 0, 32'h1000, 3, 1, 32'h1004, "R7 geu 32768");
      drive(3, 0, 1, 0, 2, 0, 32'h1000, 3, 1, 32'h1004, "R7 ltu 2");
      // R8 compact form
      drive(4, 0, 0, 0, 0, 12'hFFF, 32'h1000, 2, 1, 32'h1043, "R8 eqz max fwd");
      drive(4, 8, 0, 0, 0, 12'hFFF, 32'h1000, 2, 0, 32'h1002, "R8 nez");
      // R1 reserved kinds
      drive(5, 0, 0, 0, 0, 0, 32'h1000, 3, 0, 32'h1003, "R1 kind5");
      drive(7, 8, 1, 2, 0, 0, 32'h1000, 3, 0, 32'h1003, "R1 kind7");
      // R10 fall-through length, R11 wrap
      drive(5, 0, 0, 0, 0, 0, 32'h2000, 2, 0, 32'h2002, "R10 len2");
      drive(0, 1, 5, 5, 0, 12'h001, 32'hFFFF_FFFE, 3, 1, 32'h3, "R11 taken wrap");
      drive(0, 9, 5, 5, 0, 0, 32'hFFFF_FFFF, 3, 0, 32'h2, "R11 fall wrap");
      drive(4, 8, 0, 0, 0, 0, 32'hFFFF_FFFF, 2, 0, 32'h1, "R11 compact wrap");
      // R1 through R11 under mixed patterns
      for (int n = 0; n < 400; n++) begin
         logic [2:0]  k;
         logic [3:0]  c, cs;
         logic [31:0] a, b, pc;
         logic [11:0] off;
         logic [1:0]  len;
         logic [32:0] r;
         k   = 3'($urandom_range(0, 7));
         c   = 4'($urandom);
         cs  = 4'($urandom);
         a   = ($urandom_range(0, 4) == 0) ? 32'd0 : $urandom;
         b   = ($urandom_range(0, 3) == 0) ? a : $urandom;
         off = 12'($urandom);
         pc  = $urandom;
         len = ($urandom_range(0, 1) == 0) ? 2'd2 : 2'd3;
         r   = ref_out(k, c, a, b, cs, off, pc, len);
         drive(k, c, a, b, cs, off, pc, len, r[32], r[31:0], "R1-mix random");
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule